// File: doc/BRIEF.md
# I2C Slave General Call Decoder

This block sits beside the byte engine of an I2C slave. It watches the stream of received bytes, framed by the engine's START and STOP indications, and acts on the general call: an address byte of all zeros with the write direction. When the general call is enabled, the block acknowledges it and then reads the command byte that follows. That byte can ask the node to take a new 7-bit address from the next byte, with or without a self-reset afterwards. It can also announce a hardware master, which carries its own address in the upper seven bits. Command values that are forbidden or undefined are refused.

For every byte the engine presents, the block returns an acknowledge decision one cycle later. The engine drives that decision onto SDA. The block also holds the node's current own address and the most recent hardware master address, and keeps four status flags for the host. After an address-change-with-reset sequence, the block runs a reset window once the bus transaction closes. During that window it refuses every byte, so the node never pulls the bus low.

Top module: `gc_decoder`

## Requirements
- R1: A first byte after START of 0x00 is acknowledged only while `gc_enable` is 1. With `gc_enable` at 0 the byte is refused and no flag changes. A first byte of 0x01 (general call with the read bit) is always refused.
- R2: Each cycle with `rx_valid` high is followed, one cycle later, by `ack_valid` high for exactly one cycle with the decision on `ack` (1 = acknowledge). `ack_valid` is never high in any other cycle, and `ack` is 0 whenever `ack_valid` is 0.
- R3: After an acknowledged general call, a command byte of 0x06 is acknowledged, and so is the byte after it. In the cycle after that third byte, `own_addr` takes bits [7:1] of the third byte and flag bit 2 (address change with reset) sets. `own_addr` changes at no other time.
- R4: A command byte of 0x04 followed by a third byte loads `own_addr` from bits [7:1] of the third byte and sets flag bit 1 (address change). Both bytes are acknowledged, and no reset window follows.
- R5: An even command byte other than 0x04 and 0x06, 0x00 included, is refused. Every later byte is refused until the next START, and `own_addr` stays unchanged.
- R6: An odd command byte is acknowledged. It sets flag bit 3 (hardware general call) and places bits [7:1] of the byte on `hw_master_addr`. The bytes that follow, until STOP or START, are acknowledged when `HW_ACK_DATA` is 1 and refused when it is 0.
- R7: Once an R3 sequence completes, the next STOP or START starts a reset window. `node_reset` is high from the following cycle for exactly `RST_CYCLES` cycles. During the window every byte is refused, and a START is ignored: a 0x00 sent in the cycle after the window closes is refused.
- R8: Flag bit 0 (general call busy) sets in the same cycle as the acknowledge of the general call address. It clears in the cycle after a STOP or a START.
- R9: Flag bits 3..1 are held until the next acknowledged general call address, which clears them.
- R10: A byte presented in the same cycle as START or STOP is refused and plays no part in decoding. When STOP and START coincide, STOP wins.
- R11: After the third byte of an address change, later bytes are refused until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gc_enable | input | 1 | Enables answering the general call |
| bus_start | input | 1 | One-cycle pulse: START or repeated START seen |
| bus_stop | input | 1 | One-cycle pulse: STOP seen |
| rx_valid | input | 1 | One-cycle pulse: `rx_byte` holds a complete received byte |
| rx_byte | input | 8 | Received byte, MSB first on the wire |
| ack_valid | output | 1 | Decision for the previous cycle's byte is on `ack` |
| ack | output | 1 | 1 = acknowledge, 0 = refuse |
| own_addr | output | 7 | Current own slave address |
| hw_master_addr | output | 7 | Address carried by the latest hardware general call |
| node_reset | output | 1 | Node self-reset window after an address-change-with-reset |
| gc_flags | output | 4 | [3] hardware call, [2] address change with reset, [1] address change, [0] busy |

## Verification
The bench builds the block with `RST_CYCLES` set to 5, so that the whole reset window, and the bytes and START that fall inside it and just after it, fit into a short stimulus. It uses `HW_ACK_DATA` at 1, so data bytes after a hardware general call are acknowledged, and `OWN_ADDR_INIT` at 0x2A, so the first address rewrite shows as a visible change. With these values every command class can be reached: coincident START/STOP and byte strobes, repeated START in the middle of a sequence, and a general call refused while disabled.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

   typedef enum logic [2:0] {
      ST_SKIP,
      ST_FIRST,
      ST_CMD,
      ST_NEWA,
      ST_NEWA_RST,
      ST_HWGC
   } gc_state_e;

   typedef enum logic [1:0] {
      CL_ADDR_RST,
      CL_ADDR_ONLY,
      CL_HW,
      CL_BAD
   } gc_class_e;

   localparam int FL_BUSY  = 0;
   localparam int FL_ADDR  = 1;
   localparam int FL_RST   = 2;
   localparam int FL_HW    = 3;
   localparam int FL_COUNT = 4;

endpackage

// File: rtl/gcd_decode.sv
module gcd_decode
   import gcd_pkg::*;
#(
   parameter int              BYTE_W   = 8,
   parameter logic [BYTE_W-1:0] CMD_RST  = 8'h06,
   parameter logic [BYTE_W-1:0] CMD_ADDR = 8'h04
) (
   input  logic [BYTE_W-1:0] byte_i,
   output logic              gc_hit_o,
   output gc_class_e         cls_o
);

   always_comb begin
      gc_hit_o = (byte_i == '0);
      if (byte_i[0])
         cls_o = CL_HW;
      else if (byte_i == CMD_RST)
         cls_o = CL_ADDR_RST;
      else if (byte_i == CMD_ADDR)
         cls_o = CL_ADDR_ONLY;
      else
         cls_o = CL_BAD;
   end

endmodule

// File: rtl/gcd_fsm.sv
module gcd_fsm
   import gcd_pkg::*;
#(
   parameter int HW_ACK_DATA = 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en_i,
   input  logic      in_reset_i,
   input  logic      bus_start_i,
   input  logic      bus_stop_i,
   input  logic      byte_valid_i,
   input  logic      gc_hit_i,
   input  gc_class_e cls_i,
   output logic      ack_valid_o,
   output logic      ack_o,
   output logic      gc_ack_o,
   output logic      hw_hit_o,
   output logic      load_o,
   output logic      load_rst_o
);

   gc_state_e state_q, state_d;
   logic      dec_ack;
   logic      hw_data_ack;

   generate
      if (HW_ACK_DATA != 0) begin : g_hw_ack
         assign hw_data_ack = 1'b1;
      end else begin : g_hw_nack
         assign hw_data_ack = 1'b0;
      end
   endgenerate

   always_comb begin
      state_d    = state_q;
      dec_ack    = 1'b0;
      gc_ack_o   = 1'b0;
      hw_hit_o   = 1'b0;
      load_o     = 1'b0;
      load_rst_o = 1'b0;
      if (in_reset_i) begin
         state_d = ST_SKIP;
      end else if (bus_stop_i) begin
         state_d = ST_SKIP;
      end else if (bus_start_i) begin
         state_d = ST_FIRST;
      end else if (byte_valid_i) begin
         unique case (state_q)
            ST_FIRST: begin
               if (gc_hit_i && en_i) begin
                  dec_ack  = 1'b1;
                  gc_ack_o = 1'b1;
                  state_d  = ST_CMD;
               end else begin
                  state_d = ST_SKIP;
               end
            end
            ST_CMD: begin
               unique case (cls_i)
                  CL_ADDR_RST: begin
                     dec_ack = 1'b1;
                     state_d = ST_NEWA_RST;
                  end
                  CL_ADDR_ONLY: begin
                     dec_ack = 1'b1;
                     state_d = ST_NEWA;
                  end
                  CL_HW: begin
                     dec_ack  = 1'b1;
                     hw_hit_o = 1'b1;
                     state_d  = ST_HWGC;
                  end
                  default: state_d = ST_SKIP;
               endcase
            end
            ST_NEWA, ST_NEWA_RST: begin
               dec_ack    = 1'b1;
               load_o     = 1'b1;
               load_rst_o = (state_q == ST_NEWA_RST);
               state_d    = ST_SKIP;
            end
            ST_HWGC: dec_ack = hw_data_ack;
            default: state_d = ST_SKIP;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_SKIP;
         ack_valid_o <= 1'b0;
         ack_o       <= 1'b0;
      end else begin
         state_q     <= state_d;
         ack_valid_o <= byte_valid_i;
         ack_o       <= dec_ack;
      end
   end

endmodule

// File: rtl/gcd_reset_timer.sv
module gcd_reset_timer #(
   parameter int RST_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic trigger_i,
   output logic active_o
);

   localparam int CNT_W = $clog2(RST_CYCLES + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end else if (trigger_i && armed_q) begin
         cnt_q   <= CNT_W'(RST_CYCLES);
         armed_q <= 1'b0;
      end else if (arm_i) begin
         armed_q <= 1'b1;
      end
   end

   assign active_o = (cnt_q != '0);

endmodule

// File: rtl/gcd_status.sv
module gcd_status
   import gcd_pkg::*;
#(
   parameter int              ADDR_W        = 7,
   parameter logic [ADDR_W-1:0] OWN_ADDR_INIT = 7'h2A
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                gc_ack_i,
   input  logic                hw_hit_i,
   input  logic                load_i,
   input  logic                load_rst_i,
   input  logic                clr_busy_i,
   input  logic [ADDR_W-1:0]   field_i,
   output logic [ADDR_W-1:0]   own_addr_o,
   output logic [ADDR_W-1:0]   hw_addr_o,
   output logic [FL_COUNT-1:0] flags_o
);

   logic [FL_COUNT-1:0] set_v;

   always_comb begin
      set_v          = '0;
      set_v[FL_BUSY] = gc_ack_i;
      set_v[FL_HW]   = hw_hit_i;
      set_v[FL_RST]  = load_i && load_rst_i;
      set_v[FL_ADDR] = load_i && !load_rst_i;
   end

   genvar gi;
   generate
      for (gi = 0; gi < FL_COUNT; gi++) begin : g_flag
         if (gi == FL_BUSY) begin : g_busy
            always_ff @(posedge clk) begin
               if (!rst_n)
                  flags_o[gi] <= 1'b0;
               else if (set_v[gi])
                  flags_o[gi] <= 1'b1;
               else if (clr_busy_i)
                  flags_o[gi] <= 1'b0;
            end
         end else begin : g_sticky
            always_ff @(posedge clk) begin
               if (!rst_n)
                  flags_o[gi] <= 1'b0;
               else if (set_v[gi])
                  flags_o[gi] <= 1'b1;
               else if (gc_ack_i)
                  flags_o[gi] <= 1'b0;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_addr_o <= OWN_ADDR_INIT;
         hw_addr_o  <= '0;
      end else begin
         if (load_i)   own_addr_o <= field_i;
         if (hw_hit_i) hw_addr_o  <= field_i;
      end
   end

endmodule

// File: rtl/gc_decoder.sv
module gc_decoder
   import gcd_pkg::*;
#(
   parameter int          ADDR_W        = 7,
   parameter int          RST_CYCLES    = 16,
   parameter int          HW_ACK_DATA   = 1,
   parameter logic [6:0]  OWN_ADDR_INIT = 7'h2A,
   parameter logic [7:0]  CMD_RST       = 8'h06,
   parameter logic [7:0]  CMD_ADDR      = 8'h04
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                gc_enable,
   input  logic                bus_start,
   input  logic                bus_stop,
   input  logic                rx_valid,
   input  logic [7:0]          rx_byte,
   output logic                ack_valid,
   output logic                ack,
   output logic [6:0]          own_addr,
   output logic [6:0]          hw_master_addr,
   output logic                node_reset,
   output logic [FL_COUNT-1:0] gc_flags
);

   localparam int BYTE_W = ADDR_W + 1;

   generate
      if (ADDR_W != 7) begin : g_bad_width
         $error("gc_decoder: ADDR_W must be 7");
      end
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("gc_decoder: RST_CYCLES must be at least 1");
      end
      if (CMD_RST[0] || CMD_ADDR[0] || (CMD_RST == CMD_ADDR) || (CMD_RST == '0) || (CMD_ADDR == '0)) begin : g_bad_cmd
         $error("gc_decoder: command codes must be distinct, even and nonzero");
      end
   endgenerate

   gc_class_e cls;
   logic      gc_hit;
   logic      in_reset;
   logic      gc_ack_ev, hw_ev, load_ev, load_rst_ev;

   gcd_decode #(
      .BYTE_W   (BYTE_W),
      .CMD_RST  (CMD_RST),
      .CMD_ADDR (CMD_ADDR)
   ) u_decode (
      .byte_i   (rx_byte),
      .gc_hit_o (gc_hit),
      .cls_o    (cls)
   );

   gcd_fsm #(
      .HW_ACK_DATA (HW_ACK_DATA)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (gc_enable),
      .in_reset_i   (in_reset),
      .bus_start_i  (bus_start),
      .bus_stop_i   (bus_stop),
      .byte_valid_i (rx_valid),
      .gc_hit_i     (gc_hit),
      .cls_i        (cls),
      .ack_valid_o  (ack_valid),
      .ack_o        (ack),
      .gc_ack_o     (gc_ack_ev),
      .hw_hit_o     (hw_ev),
      .load_o       (load_ev),
      .load_rst_o   (load_rst_ev)
   );

   gcd_reset_timer #(
      .RST_CYCLES (RST_CYCLES)
   ) u_rst_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_i     (load_ev && load_rst_ev),
      .trigger_i (bus_stop || bus_start),
      .active_o  (in_reset)
   );

   gcd_status #(
      .ADDR_W        (ADDR_W),
      .OWN_ADDR_INIT (OWN_ADDR_INIT)
   ) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .gc_ack_i   (gc_ack_ev),
      .hw_hit_i   (hw_ev),
      .load_i     (load_ev),
      .load_rst_i (load_rst_ev),
      .clr_busy_i (bus_stop || bus_start),
      .field_i    (rx_byte[BYTE_W-1:1]),
      .own_addr_o (own_addr),
      .hw_addr_o  (hw_master_addr),
      .flags_o    (gc_flags)
   );

   assign node_reset = in_reset;

endmodule

// File: rtl/gc_decoder_chk.sv
module gc_decoder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       gc_enable,
   input logic       bus_start,
   input logic       bus_stop,
   input logic       rx_valid,
   input logic       ack_valid,
   input logic       ack,
   input logic [6:0] own_addr,
   input logic       node_reset,
   input logic       busy
);

   // R2: decision follows each strobe by one cycle
   p_vld_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> ack_valid);

   // R2: no decision without a strobe
   p_vld_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> !ack_valid);

   // R2: ack only together with ack_valid
   p_ack_framed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> ack_valid);

   // R1: with the call disabled and no sequence open, nothing is acknowledged
   p_nack_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !gc_enable && !busy) |=> !ack);

   // R3: own address only moves after a byte
   p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> $stable(own_addr));

   // R7: node stays off the bus during its reset window
   p_quiet_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      node_reset |-> !ack);

   // R8: busy drops after STOP
   p_busy_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |=> !busy);

   // R8: busy drops after START
   p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> !busy);

endmodule

bind gc_decoder gc_decoder_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .gc_enable  (gc_enable),
   .bus_start  (bus_start),
   .bus_stop   (bus_stop),
   .rx_valid   (rx_valid),
   .ack_valid  (ack_valid),
   .ack        (ack),
   .own_addr   (own_addr),
   .node_reset (node_reset),
   .busy       (gc_flags[0])
);

// File: tb/gc_decoder_bench.sv
module gc_decoder_bench;

   localparam int         RST_N_CYC = 5;
   localparam int         HW_ACK    = 1;
   localparam logic [6:0] INIT_ADDR = 7'h2A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       gc_enable = 1'b0;
   logic       bus_start = 1'b0;
   logic       bus_stop = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       ack_valid, ack, node_reset;
   logic [6:0] own_addr, hw_master_addr;
   logic [3:0] gc_flags;

   gc_decoder #(
      .RST_CYCLES    (RST_N_CYC),
      .HW_ACK_DATA   (HW_ACK),
      .OWN_ADDR_INIT (INIT_ADDR)
   ) u_gc_decoder (
      .clk            (clk),
      .rst_n          (rst_n),
      .gc_enable      (gc_enable),
      .bus_start      (bus_start),
      .bus_stop       (bus_stop),
      .rx_valid       (rx_valid),
      .rx_byte        (rx_byte),
      .ack_valid      (ack_valid),
      .ack            (ack),
      .own_addr       (own_addr),
      .hw_master_addr (hw_master_addr),
      .node_reset     (node_reset),
      .gc_flags       (gc_flags)
   );

   always #5 clk = ~clk;

   int    total = 0;
   int    bad = 0;
   bit    done = 0;
   bit    seen_edge = 0;
   string cur_req = "RST";

   // behavioural reference: 0 skip, 1 first byte, 2 command, 3 new addr, 4 new addr+reset, 5 hw call
   int         m_state;
   int         m_cnt;
   bit         m_armed;
   bit         m_a;
   logic       m_ackv, m_ack, m_node;
   logic [6:0] m_own, m_hw;
   logic [3:0] m_flags;

   always @(posedge clk) begin
      seen_edge <= 1'b1;
      if (!rst_n) begin
         m_state = 0; m_cnt = 0; m_armed = 0;
         m_ackv = 0; m_ack = 0; m_node = 0;
         m_own = INIT_ADDR; m_hw = 7'h00; m_flags = 4'h0;
      end else begin
         m_a = 0;
         if (m_cnt > 0) begin
            m_cnt = m_cnt - 1;
            m_state = 0;
         end else if (bus_stop || bus_start) begin
            if (m_armed) begin m_cnt = RST_N_CYC; m_armed = 0; end
            m_state = bus_stop ? 0 : 1;
            m_flags[0] = 0;
         end else if (rx_valid) begin
            case (m_state)
               1: if (gc_enable && rx_byte == 8'h00) begin
                     m_a = 1; m_flags = 4'b0001; m_state = 2;
                  end else m_state = 0;
               2: if (rx_byte == 8'h06) begin m_a = 1; m_state = 4; end
                  else if (rx_byte == 8'h04) begin m_a = 1; m_state = 3; end
                  else if (rx_byte[0]) begin
                     m_a = 1; m_flags[3] = 1; m_hw = rx_byte[7:1]; m_state = 5;
                  end else m_state = 0;
               3, 4: begin
                  m_a = 1; m_own = rx_byte[7:1];
                  if (m_state == 4) begin m_flags[2] = 1; m_armed = 1; end
                  else m_flags[1] = 1;
                  m_state = 0;
               end
               5: m_a = (HW_ACK != 0);
               default: ;
            endcase
         end
         m_ackv = rx_valid;
         m_ack = m_a;
         m_node = (m_cnt != 0);
      end
   end

   task automatic check(string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (seen_edge && !done) begin
         check("ack_valid", 32'(ack_valid), 32'(m_ackv));
         check("ack", 32'(ack), 32'(m_ack));
         check("own_addr", 32'(own_addr), 32'(m_own));
         check("hw_master_addr", 32'(hw_master_addr), 32'(m_hw));
         check("node_reset", 32'(node_reset), 32'(m_node));
         check("gc_flags", 32'(gc_flags), 32'(m_flags));
      end
   end

   task automatic drive(input bit st, input bit sp, input bit v, input logic [7:0] b);
      @(negedge clk);
      bus_start = st; bus_stop = sp; rx_valid = v; rx_byte = b;
      @(negedge clk);
      bus_start = 0; bus_stop = 0; rx_valid = 0;
   endtask

   task automatic do_start();         drive(1, 0, 0, 8'h00); endtask
   task automatic do_stop();          drive(0, 1, 0, 8'h00); endtask
   task automatic do_byte(logic [7:0] b); drive(0, 0, 1, b);  endtask
   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      idle(2);
      // R2 reset state and idle cycles compared every clock above

      cur_req = "R1";                        // disabled general call refused
      do_start(); do_byte(8'h00); do_stop();
      gc_enable = 1;
      do_start(); do_byte(8'h01); do_stop();  // R1 read-direction call refused

      cur_req = "R4";                        // address change without reset
      do_start(); do_byte(8'h00); do_byte(8'h04); do_byte(8'hA4);
      cur_req = "R11";
      do_byte(8'h11); do_byte(8'h00);
      do_stop(); idle(3);

      cur_req = "R5";                        // forbidden and undefined commands
      do_start(); do_byte(8'h00); do_byte(8'h00); do_byte(8'h55); do_stop();
      do_start(); do_byte(8'h00); do_byte(8'h08); do_byte(8'h33); do_stop();

      cur_req = "R6";                        // hardware general call
      do_start(); do_byte(8'h00); do_byte(8'h6B); do_byte(8'h12); do_byte(8'h34);
      do_stop();

      cur_req = "R9";                        // flags clear on a new call
      do_start(); do_byte(8'h00); do_stop();

      cur_req = "R3";                        // address change with reset
      do_start(); do_byte(8'h00); do_byte(8'h06); do_byte(8'h3C);
      cur_req = "R7";
      do_stop();
      do_byte(8'h00); do_start(); do_byte(8'h00);
      idle(4);
      do_start(); do_byte(8'h00); do_byte(8'h04); do_byte(8'h10); do_stop();
      // window re-armed via repeated START
      do_start(); do_byte(8'h00); do_byte(8'h06); do_byte(8'h7E);
      do_start(); idle(8);

      cur_req = "R10";                       // coincident START/STOP and bytes
      drive(1, 0, 1, 8'h00);
      do_byte(8'h00);
      do_start(); do_byte(8'h00);
      cur_req = "R8";
      do_start(); do_byte(8'h00); do_byte(8'h04);
      cur_req = "R10";
      drive(1, 1, 1, 8'h00);
      do_byte(8'h00);
      do_start(); drive(0, 1, 1, 8'h00);
      idle(3);

      cur_req = "R1";                        // disabled again
      gc_enable = 0;
      do_start(); do_byte(8'h00); do_byte(8'h04); do_stop();
      idle(2);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule